// File: doc/BRIEF.md
# Streaming stride permutation unit

This block takes a frame of N words that arrives LANES words per beat in natural order and sends the same words out LANES per beat, regrouped so that words S apart in the input frame sit next to each other in the output. Viewing the frame as a matrix of M = N/S rows of S columns, the input walks it row by row and the output walks it column by column. It is the reorder step that sits between two stages of a streaming transform pipeline.

The path has three parts. A log-depth network of 2x2 exchange switches rotates each input beat across the lanes. A row of LANES dual-port memory banks, each with its own address generator, moves words across beats. A second switch network rotates each read beat into output lane order. Every switch setting and address comes from constants and functions fixed by N_PTS, LANES and STRIDE. Each bank has two halves, so one frame can be written while the one before it is still read out. LANES, STRIDE and N_PTS/STRIDE are powers of two, and STRIDE >= LANES and N_PTS/STRIDE >= LANES.

Top module: `spp_stream_perm`

## Requirements
- R1: After reset, out_valid is 0, and it stays 0 while in_valid has never been 1.
- R2: Lane l of input beat t of a frame, at in_data bits [l*WORD_W +: WORD_W], is frame word t*LANES+l. Output beat u of the same frame carries, on lane k at out_data bits [k*WORD_W +: WORD_W], the frame word (o mod M)*STRIDE + (o div M), where o = u*LANES+k and M = N_PTS/STRIDE. Frames leave in the order they arrived.
- R3: A frame that arrives on consecutive cycles into an empty unit gives its first out_valid exactly D+4 cycles after its first input beat. D is the largest value, over all output beats u, of (the highest input beat index holding a word of beat u) minus u. With the defaults this is 17 cycles.
- R4: Each frame produces exactly N_PTS/LANES output beats. Once the output of a frame that arrived without gaps has started, those beats leave on consecutive cycles.
- R5: A frame that follows another with no idle cycle between them is sent out with no idle cycle between the last beat of the first frame and the first beat of the second.
- R6: Idle cycles (in_valid = 0) inside a frame do not change which words come out or in what order.
- R7: in_data is ignored in every cycle where in_valid is 0.
- R8: The unit holds at most two frames. A new frame's first beat is accepted only after the oldest held frame has been fully read out, and this always holds when input frames run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input beat is present |
| in_data | input | LANES*WORD_W | Input beat, lane l at bits [l*WORD_W +: WORD_W] |
| out_valid | output | 1 | An output beat is present |
| out_data | output | LANES*WORD_W | Output beat, lane k at bits [k*WORD_W +: WORD_W] |

## Verification
Every word carries its frame number and its index, so a word that lands in the wrong lane, beat or frame is flagged the moment it leaves. The first frame runs without gaps into an empty unit, which pins down the start delay and shows that one frame leaves without bubbles. A pair of back-to-back frames shows whether the two bank halves hand over cleanly at the frame boundary. Frames with idle cycles carrying junk data tell a counter that moves only on valid beats apart from one that moves every cycle, and show whether idle data can leak into the stream.

// File: rtl/spp_pkg.sv
package spp_pkg;

  // ceil(log2(v)) for v >= 1
  function automatic int ilog2(int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++)
      if ((1 << i) < v) r = i + 1;
    return r;
  endfunction

  // position of the upper input of switch sw in the column that pairs lanes differing in bit col
  function automatic int sw_upper(int col, int sw);
    return ((sw >> col) << (col + 1)) | (sw & ((1 << col) - 1));
  endfunction

  // Routing of a lane rotation by rot through the columns, lowest bit first.
  // Before column col a word's position has destination bits below col and
  // source bits from col upward. The switch crosses when its upper word must
  // leave with bit col set.
  function automatic bit sw_cross(int rot, int col, int up_pos, int lanes);
    int mask;
    int src;
    int dst;
    mask = (1 << col) - 1;
    src  = (up_pos & ~mask) | ((up_pos - rot + lanes) & mask);
    dst  = (src + rot) % lanes;
    return ((dst >> col) & 1) == 1;
  endfunction

  // highest input beat index that holds a word of output beat u
  function automatic int beat_need(int u, int n, int p, int s);
    int m;
    int o;
    int row0;
    int col;
    m    = n / s;
    o    = u * p;
    col  = o / m;
    row0 = o % m;
    return ((row0 + p - 1) * s + col) / p;
  endfunction

  // number of beats the first read trails the first write so that reads never wait
  function automatic int lead_beats(int n, int p, int s);
    int best;
    best = 0;
    for (int u = 0; u < n / p; u++)
      if (beat_need(u, n, p, s) - u > best) best = beat_need(u, n, p, s) - u;
    return best;
  endfunction

endpackage

// File: rtl/spp_xnet.sv
// Lane rotation over log2(P) columns of P/2 exchange switches, one control bit each.
module spp_xnet #(
  parameter int W = 16,
  parameter int P = 4
) (
  input  logic [W-1:0]                 din  [P],
  input  logic [spp_pkg::ilog2(P)-1:0] rot,
  output logic [W-1:0]                 dout [P]
);
  import spp_pkg::*;

  localparam int LOGP = ilog2(P);
  localparam int HALF = P / 2;
  localparam int NSW  = HALF * LOGP;

  // settings for every rotation amount, fixed at elaboration
  function automatic logic [P*NSW-1:0] build_tab();
    logic [P*NSW-1:0] t;
    t = '0;
    for (int r = 0; r < P; r++)
      for (int c = 0; c < LOGP; c++)
        for (int s = 0; s < HALF; s++)
          t[r*NSW + c*HALF + s] = sw_cross(r, c, sw_upper(c, s), P);
    return t;
  endfunction

  localparam logic [P*NSW-1:0] CTL_TAB = build_tab();

  logic [NSW-1:0] ctl;
  logic [W-1:0]   col_d [LOGP+1][P];

  assign ctl = CTL_TAB[int'(rot)*NSW +: NSW];

  for (genvar l = 0; l < P; l++) begin : g_edge
    assign col_d[0][l] = din[l];
    assign dout[l]     = col_d[LOGP][l];
  end

  for (genvar c = 0; c < LOGP; c++) begin : g_col
    for (genvar s = 0; s < HALF; s++) begin : g_sw
      localparam int UP = sw_upper(c, s);
      localparam int LO = UP + (1 << c);
      assign col_d[c+1][UP] = ctl[c*HALF+s] ? col_d[c][LO] : col_d[c][UP];
      assign col_d[c+1][LO] = ctl[c*HALF+s] ? col_d[c][UP] : col_d[c][LO];
    end
  end

endmodule

// File: rtl/spp_bank.sv
// One dual-port bank: synchronous write, combinational read.
module spp_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/spp_agu.sv
// Read address of one bank for a given output beat of a frame.
module spp_agu #(
  parameter int N    = 64,
  parameter int P    = 4,
  parameter int S    = 8,
  parameter int BANK = 0,
  parameter int LOGF = 4
) (
  input  logic [LOGF-1:0] rd_beat,
  input  logic            half,
  output logic [LOGF:0]   raddr
);
  localparam int M = N / S;

  always_comb begin
    int o;
    int col;
    int row0;
    int k;
    o     = int'(rd_beat) * P;
    col   = o / M;
    row0  = o % M;
    // output lane fed by this bank; the word sits in row row0+k, column col
    k     = (BANK - (col % P) + P) % P;
    raddr = {half, LOGF'((row0 + k) * (S / P) + col / P)};
  end

endmodule

// File: rtl/spp_stream_perm.sv
module spp_stream_perm #(
  parameter int WORD_W = 16,
  parameter int N_PTS  = 64,
  parameter int LANES  = 4,
  parameter int STRIDE = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*WORD_W-1:0] in_data,
  output logic                    out_valid,
  output logic [LANES*WORD_W-1:0] out_data
);
  import spp_pkg::*;

  localparam int FB     = N_PTS / LANES;            // beats per frame
  localparam int M      = N_PTS / STRIDE;           // rows of the frame matrix
  localparam int LOGP   = ilog2(LANES);
  localparam int LOGF   = ilog2(FB);
  localparam int LOG_SP = ilog2(STRIDE / LANES);
  localparam int DEPTH  = 2 * FB;                   // two frame halves per bank
  localparam int AW     = LOGF + 1;
  localparam int DLEAD  = lead_beats(N_PTS, LANES, STRIDE);

  // ---------------- input rotation ----------------
  logic [WORD_W-1:0] in_lane  [LANES];
  logic [WORD_W-1:0] net_in_q [LANES];
  logic [WORD_W-1:0] s1_data  [LANES];
  logic              s1_valid;
  logic [LOGF-1:0]   in_beat;
  logic [LOGP-1:0]   rot_in;

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign in_lane[l] = in_data[l*WORD_W +: WORD_W];
  end

  // row index of the beat picks the rotation, so words of one row spread over all banks
  assign rot_in = LOGP'(in_beat >> LOG_SP);

  spp_xnet #(.W(WORD_W), .P(LANES)) u_net_in (
    .din (in_lane),
    .rot (rot_in),
    .dout(net_in_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_beat  <= '0;
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) in_beat <= in_beat + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    s1_data <= net_in_q;
  end

  // ---------------- write side ----------------
  logic [LOGF-1:0] wr_cnt;
  logic [1:0]      wr_frm;
  logic            wr_last;

  assign wr_last = s1_valid && (wr_cnt == LOGF'(FB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= '0;
      wr_frm <= '0;
    end else if (s1_valid) begin
      wr_cnt <= wr_cnt + 1'b1;
      if (wr_last) wr_frm <= wr_frm + 1'b1;
    end
  end

  // ---------------- read side ----------------
  logic [LOGF-1:0]   rd_u;
  logic [1:0]        rd_frm;
  logic              rd_same;
  logic              rd_fire;
  logic              rd_last;
  logic [LOGP-1:0]   rot_out;
  logic [AW-1:0]     bank_ra [LANES];
  logic [WORD_W-1:0] bank_rd [LANES];

  assign rd_same = (wr_frm == rd_frm);
  // an older frame is complete; the one being written is read once DLEAD beats are ahead
  assign rd_fire = !rd_same || (int'(wr_cnt) > DLEAD + int'(rd_u));
  assign rd_last = rd_fire && (rd_u == LOGF'(FB - 1));

  always_comb begin
    int col;
    col     = (int'(rd_u) * LANES) / M;
    rot_out = LOGP'((LANES - (col % LANES)) % LANES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_u   <= '0;
      rd_frm <= '0;
    end else if (rd_fire) begin
      rd_u <= rd_u + 1'b1;
      if (rd_last) rd_frm <= rd_frm + 1'b1;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_bank
    spp_agu #(.N(N_PTS), .P(LANES), .S(STRIDE), .BANK(j), .LOGF(LOGF)) u_agu (
      .rd_beat(rd_u),
      .half   (rd_frm[0]),
      .raddr  (bank_ra[j])
    );

    spp_bank #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk  (clk),
      .we   (s1_valid),
      .waddr({wr_frm[0], wr_cnt}),
      .wdata(s1_data[j]),
      .raddr(bank_ra[j]),
      .rdata(bank_rd[j])
    );
  end

  // ---------------- output rotation ----------------
  logic [WORD_W-1:0] s2_data   [LANES];
  logic [WORD_W-1:0] net_out_q [LANES];
  logic [LOGP-1:0]   s2_rot;
  logic              s2_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= rd_fire;
  end

  always_ff @(posedge clk) begin
    s2_data <= bank_rd;
    s2_rot  <= rot_out;
  end

  spp_xnet #(.W(WORD_W), .P(LANES)) u_net_out (
    .din (s2_data),
    .rot (s2_rot),
    .dout(net_out_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_valid;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) out_data[l*WORD_W +: WORD_W] <= net_out_q[l];
  end

  // ---------------- assertions ----------------
  logic [1:0] frm_gap;
  assign frm_gap = wr_frm - rd_frm;

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> (frm_gap <= 2'd1)); // R8

  AST_RD_BEHIND_WR: assert property (@(posedge clk) disable iff (!rst_n)
    frm_gap != 2'd3); // R8

  AST_READ_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && rd_same) |-> (int'(wr_cnt) > beat_need(int'(rd_u), N_PTS, LANES, STRIDE))); // R2

  AST_OUT_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(rd_fire, 2)); // R4

endmodule

// File: tb/sim_spp_stream_perm.sv
module sim_spp_stream_perm;
  localparam int W = 16;
  localparam int N = 64;
  localparam int P = 4;
  localparam int S = 8;
  localparam int F = N / P;
  localparam int M = N / S;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [P*W-1:0] in_data = '0;
  logic           out_valid;
  logic [P*W-1:0] out_data;

  always #2 clk = ~clk; // 4 ns period

  spp_stream_perm #(.WORD_W(W), .N_PTS(N), .LANES(P), .STRIDE(S)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int beats = 0;
  int out_t [256];
  int t_first_in = -1;
  bit finished = 1'b0;
  logic [W-1:0] exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int got, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  // R2 reference: compare every output beat against the queue
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      int bad_lane;
      int bad_got;
      int bad_exp;
      bad_lane = -1;
      bad_got = 0;
      bad_exp = 0;
      if (beats < 256) out_t[beats] = cyc;
      for (int k = 0; k < P; k++) begin
        int e;
        e = -1;
        if (exp_q.size() > 0) e = int'(exp_q.pop_front());
        if (bad_lane < 0 && int'(out_data[k*W +: W]) != e) begin
          bad_lane = k;
          bad_got = int'(out_data[k*W +: W]);
          bad_exp = e;
        end
      end
      checks++;
      if (bad_lane >= 0) begin
        errors++;
        $display("FAIL R2 beat %0d lane %0d: got %0d expected %0d", beats, bad_lane, bad_got, bad_exp);
      end
      beats++;
    end
  end

  function automatic int ref_latency();
    int worst;
    worst = 0;
    for (int u = 0; u < F; u++) begin
      int last;
      last = 0;
      for (int k = 0; k < P; k++) begin
        int o;
        int idx;
        o = u * P + k;
        idx = (o % M) * S + o / M;
        if (idx / P > last) last = idx / P;
      end
      if (last - u > worst) worst = last - u;
    end
    return worst + 4;
  endfunction

  task automatic push_expected(int fid);
    for (int o = 0; o < N; o++) exp_q.push_back(W'(fid * 100 + (o % M) * S + o / M));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
      in_data  = {P{16'hBEEF}} ^ P*W'(i * 7); // R7: junk while idle
    end
  endtask

  task automatic send_frame(int fid, bit gappy);
    push_expected(fid);
    for (int t = 0; t < F; t++) begin
      if (gappy && (t % 3 != 0)) idle(1 + (t % 2));
      @(posedge clk); #1;
      in_valid = 1'b1;
      for (int l = 0; l < P; l++) in_data[l*W +: W] = W'(fid * 100 + t * P + l);
      if (fid == 0 && t == 0) t_first_in = cyc;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: nothing comes out after reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    end
    // R7: junk on in_data while idle produces nothing
    idle(8);
    @(negedge clk);
    chk(out_valid == 1'b0 && beats == 0, "R7 idle junk gave output", beats, 0);

    // single gapless frame: R3 latency, R4 contiguous beats
    send_frame(0, 1'b0);
    idle(40);
    chk(out_t[0] - t_first_in == ref_latency(), "R3 first output delay", out_t[0] - t_first_in, ref_latency());
    chk(out_t[F-1] - out_t[0] == F - 1, "R4 frame beats contiguous", out_t[F-1] - out_t[0], F - 1);
    chk(beats == F, "R4 beats per frame", beats, F);

    // back-to-back frames: R5 no bubble, R8 two frames held
    send_frame(1, 1'b0);
    send_frame(2, 1'b0);
    idle(50);
    chk(out_t[3*F-1] - out_t[F] == 2*F - 1, "R5 back-to-back output gapless", out_t[3*F-1] - out_t[F], 2*F - 1);
    chk(beats == 3*F, "R8 all beats of two held frames", beats, 3*F);

    // frame with idle cycles and junk: R6, R7
    send_frame(3, 1'b1);
    idle(60);
    chk(beats == 4*F, "R6 gappy frame beat count", beats, 4*F);
    chk(exp_q.size() == 0, "R6 gappy frame words consumed", exp_q.size(), 0);

    // gapless frame followed at once by a gappy one
    send_frame(4, 1'b0);
    send_frame(5, 1'b1);
    idle(70);
    chk(out_t[5*F-1] - out_t[4*F] == F - 1, "R4 second gapless frame contiguous", out_t[5*F-1] - out_t[4*F], F - 1);
    chk(beats == 6*F, "R2 total output beats", beats, 6*F);
    chk(exp_q.size() == 0, "R2 no words left over", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired: got %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule